// File: doc/BRIEF.md
# SMBus Host Transaction Engine

This block is a register-programmed SMBus master. It carries out four short host transactions: send byte, receive byte, write byte-data and read byte-data. Software loads a target register, a command register and a data register, then writes the control register with a protocol mode and the start bit. Software polls the status register until the busy bit falls, and then reads either the completion flag or the device-error flag. The clock and data lines are open-drain. Each line has a pull-low enable output and a sensed-level input.

A quarter-period tick comes from a programmable divider. A Moore state machine walks through the bus phases and holds each phase for one tick. Its states are `SQ_IDLE`, `SQ_START`, `SQ_XFER` (eight data bits plus the acknowledge slot), `SQ_RESTART` and `SQ_STOP`. A step table picks the transitions out of `SQ_XFER` and `SQ_RESTART`. The table is indexed by mode, direction and step number, and each entry is one of: next write byte (`SQ_XFER`), read byte (`SQ_XFER`), repeated start (`SQ_RESTART`) or end (`SQ_STOP`). Two other transitions do not use the table. A refused acknowledge sends `SQ_XFER` straight to `SQ_STOP`. `SQ_STOP` always returns to `SQ_IDLE`. During the high phase of SCL the machine waits until the sensed clock is actually high.

Register offsets (reg_addr): 0 status, 1 control, 2 target, 3 command, 4 data, 5 divider.

Top module: `smb_host`

## Requirements
- R1: After reset the status reads 0x00, both pull-low enables are 0 and the divider reads back its reset value (default 9).
- R2: Target register bits [7:1] hold the 7-bit device address and bit 0 holds the direction (1 = read). In byte mode (control bits [4:2] = 001) with direction 0, the bus carries START, the target byte as written, then the data register byte, then STOP.
- R3: In byte mode with direction 1, the bus carries START and the target byte. The engine then clocks in one byte, answers it with NACK and stores it in the data register.
- R4: In byte-data mode (control bits [4:2] = 010) with direction 0, the bus carries START, {address,0}, the command byte and the data byte, then STOP.
- R5: In byte-data mode with direction 1, the bus carries START, {address,0}, the command byte, a repeated START and {address,1}. The engine then reads one byte, answers it with NACK, stores it in the data register and issues STOP.
- R6: Status bit 0 (busy) is 1 from the cycle after an accepted start until the STOP ends. While busy, bits 1 and 2 read 0. A successful transaction leaves the status at exactly 0x02 (bit 1 = done).
- R7: If the target does not acknowledge the address, command or write-data byte, the engine sends STOP immediately and the status becomes exactly 0x04 (bit 2 = device error). The data register keeps its value.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit. Writing to bit 0 has no effect.
- R9: A start request (control bit 6 = 1) is accepted only when the status reads 0x00 and the written mode is 001 or 010. Any other start request is ignored, and the bus is not touched.
- R10: While busy, writes to the control, target, command, data and divider registers are ignored.
- R11: One SCL quarter-phase lasts (divider+1) clock cycles, so successive SCL rising edges within a byte are 4*(divider+1) cycles apart when the target does not hold SCL low.
- R12: The control register reads back every bit as written except bit 6 (start), which always reads 0.
- R13: Whenever the engine is not busy, both pull-low enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_in | input | 1 | Sensed level of the data line |
| sda_oe | output | 1 | 1 pulls the data line low |

## Verification
Two situations are hard to reach from the ports. One is a start request that arrives mid-transaction, together with register writes that arrive during the same transaction. The other is an acknowledge refused on a later byte, not on the address. The bench reaches the first by slowing the divider so that a byte-data write stays busy long enough for it to rewrite the command, data and target registers and to repeat the start request. It then checks that the target saw only the original bytes and that only one STOP occurred. For the second, the bench's behavioural target acknowledges its address but is switched to refuse data bytes. The bench also keeps a model of when the bus must be idle and compares the pull-low enables against that model on every clock.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam logic [2:0] OFS_STAT  = 3'd0;
    localparam logic [2:0] OFS_CTRL  = 3'd1;
    localparam logic [2:0] OFS_TADDR = 3'd2;
    localparam logic [2:0] OFS_CMD   = 3'd3;
    localparam logic [2:0] OFS_DATA  = 3'd4;
    localparam logic [2:0] OFS_DIV   = 3'd5;

    localparam logic [2:0] MODE_BYTE  = 3'b001;
    localparam logic [2:0] MODE_BDATA = 3'b010;

    localparam int CTRL_GO   = 6;
    localparam int STAT_DONE = 1;
    localparam int STAT_DERR = 2;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_START, SQ_XFER, SQ_RESTART, SQ_STOP
    } sq_state_t;

    typedef enum logic [1:0] { OP_WR, OP_RD, OP_RS, OP_END } op_t;

    typedef struct packed {
        op_t        op;
        logic [7:0] val;
    } step_t;

    // Step table: what happens at step i of a transaction.
    function automatic step_t step_at(input logic [2:0] mode, input logic [7:0] ta,
                                      input logic [7:0] cmd, input logic [7:0] dat,
                                      input logic [2:0] i);
        step_t s;
        logic  rd;
        rd = ta[0];
        s.op  = OP_END;
        s.val = 8'h00;
        if (mode == MODE_BDATA) begin
            case (i)
                3'd0: begin s.op = OP_WR; s.val = {ta[7:1], 1'b0}; end
                3'd1: begin s.op = OP_WR; s.val = cmd; end
                3'd2: begin s.op = rd ? OP_RS : OP_WR; s.val = dat; end
                3'd3: begin s.op = rd ? OP_WR : OP_END; s.val = {ta[7:1], 1'b1}; end
                3'd4: begin s.op = rd ? OP_RD : OP_END; end
                default: s.op = OP_END;
            endcase
        end else begin
            case (i)
                3'd0: begin s.op = OP_WR; s.val = ta; end
                3'd1: begin s.op = rd ? OP_RD : OP_WR; s.val = dat; end
                default: s.op = OP_END;
            endcase
        end
        return s;
    endfunction

    function automatic op_t op_at(input logic [2:0] mode, input logic [7:0] ta,
                                  input logic [7:0] cmd, input logic [7:0] dat,
                                  input logic [2:0] i);
        step_t s;
        s = step_at(mode, ta, cmd, dat, i);
        return s.op;
    endfunction

endpackage

// File: rtl/smb_tick.sv
module smb_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= tick ? div : cnt_q - 1'b1;
    end
endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start,
    input  logic [2:0] mode,
    input  logic [7:0] taddr,
    input  logic [7:0] cmd,
    input  logic [7:0] dat,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       busy,
    output logic       fin,
    output logic       fin_err,
    output logic       rx_valid,
    output logic [7:0] rx_byte
);
    sq_state_t  state_q, state_d;
    logic [1:0] q_q, q_d;
    logic [3:0] bc_q, bc_d;
    logic [2:0] idx_q, idx_d;
    logic [7:0] sh_q, sh_d;
    logic       rbit_q, rbit_d;
    logic       err_q, err_d;
    logic       adv;
    op_t        cur_op;
    step_t      nxt;

    assign cur_op  = op_at(mode, taddr, cmd, dat, idx_q);
    assign nxt     = step_at(mode, taddr, cmd, dat, idx_q + 3'd1);
    assign adv     = tick && !(q_q == 2'd2 && !scl_in);
    assign busy    = (state_q != SQ_IDLE);
    assign rx_byte = sh_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            q_q     <= '0;
            bc_q    <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
            rbit_q  <= 1'b1;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            q_q     <= q_d;
            bc_q    <= bc_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
            rbit_q  <= rbit_d;
            err_q   <= err_d;
        end
    end

    // Next state
    always_comb begin
        state_d  = state_q;
        q_d      = q_q;
        bc_d     = bc_q;
        idx_d    = idx_q;
        sh_d     = sh_q;
        rbit_d   = rbit_q;
        err_d    = err_q;
        fin      = 1'b0;
        fin_err  = 1'b0;
        rx_valid = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (start) begin
                state_d = SQ_START;
                q_d     = '0;
                idx_d   = '0;
                err_d   = 1'b0;
                sh_d    = step_at(mode, taddr, cmd, dat, 3'd0).val;
            end
            SQ_START: if (tick) begin
                q_d = q_q + 2'd1;
                if (q_q == 2'd1) begin
                    state_d = SQ_XFER;
                    q_d     = '0;
                    bc_d    = '0;
                end
            end
            SQ_XFER: if (adv) begin
                q_d = q_q + 2'd1;
                if (q_q == 2'd2) rbit_d = sda_in;
                if (q_q == 2'd3) begin
                    if (bc_q != 4'd8) begin
                        sh_d = {sh_q[6:0], rbit_q};
                        bc_d = bc_q + 4'd1;
                    end else if (cur_op == OP_WR && rbit_q) begin
                        err_d   = 1'b1;
                        state_d = SQ_STOP;
                    end else begin
                        rx_valid = (cur_op == OP_RD);
                        idx_d    = idx_q + 3'd1;
                        bc_d     = '0;
                        sh_d     = nxt.val;
                        unique case (nxt.op)
                            OP_WR, OP_RD: state_d = SQ_XFER;
                            OP_RS:        state_d = SQ_RESTART;
                            OP_END:       state_d = SQ_STOP;
                        endcase
                    end
                end
            end
            SQ_RESTART: if (adv) begin
                q_d = q_q + 2'd1;
                if (q_q == 2'd3) begin
                    idx_d   = idx_q + 3'd1;
                    bc_d    = '0;
                    sh_d    = nxt.val;
                    state_d = SQ_XFER;
                end
            end
            SQ_STOP: if (adv) begin
                q_d = q_q + 2'd1;
                if (q_q == 2'd3) begin
                    state_d = SQ_IDLE;
                    fin     = 1'b1;
                    fin_err = err_q;
                end
            end
        endcase
    end

    // Line drive (Moore)
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            SQ_IDLE: ;
            SQ_START: begin
                sda_oe = 1'b1;
                scl_oe = (q_q == 2'd1);
            end
            SQ_XFER: begin
                scl_oe = (q_q == 2'd0) || (q_q == 2'd3);
                sda_oe = (bc_q != 4'd8) && (cur_op == OP_WR) && !sh_q[7];
            end
            SQ_RESTART: begin
                scl_oe = (q_q == 2'd0);
                sda_oe = (q_q == 2'd3);
            end
            SQ_STOP: begin
                scl_oe = (q_q == 2'd0);
                sda_oe = (q_q != 2'd3);
            end
        endcase
    end
endmodule

// File: rtl/smb_host.sv
module smb_host
    import smb_pkg::*;
#(
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_in,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe
);
    logic [7:0]       ctrl_q, taddr_q, cmd_q, data_q;
    logic [DIV_W-1:0] div_q;
    logic             done_q, err_q;
    logic             busy, tick, fin, fin_err, rx_valid;
    logic [7:0]       rx_byte;
    logic             go_req, mode_ok, start_go, wr_ok;
    logic [2:0]       mode_eff;

    assign go_req   = reg_wr && reg_addr == OFS_CTRL && reg_wdata[CTRL_GO];
    assign mode_ok  = reg_wdata[4:2] == MODE_BYTE || reg_wdata[4:2] == MODE_BDATA;
    assign start_go = go_req && mode_ok && !busy && !done_q && !err_q;
    assign mode_eff = start_go ? reg_wdata[4:2] : ctrl_q[4:2];
    assign wr_ok    = reg_wr && !busy;

    smb_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .div(div_q), .tick(tick)
    );

    smb_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_go),
        .mode(mode_eff), .taddr(taddr_q), .cmd(cmd_q), .dat(data_q),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .busy(busy), .fin(fin), .fin_err(fin_err),
        .rx_valid(rx_valid), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            taddr_q <= '0;
            cmd_q   <= '0;
            data_q  <= '0;
            div_q   <= DIV_W'(DIV_INIT);
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (reg_addr)
                    OFS_CTRL:  ctrl_q  <= reg_wdata & ~(8'd1 << CTRL_GO);
                    OFS_TADDR: taddr_q <= reg_wdata;
                    OFS_CMD:   cmd_q   <= reg_wdata;
                    OFS_DATA:  data_q  <= reg_wdata;
                    OFS_DIV:   div_q   <= DIV_W'(reg_wdata);
                    default: ;
                endcase
            end
            if (rx_valid) data_q <= rx_byte;
            if (fin) begin
                done_q <= !fin_err;
                err_q  <= fin_err;
            end else if (reg_wr && reg_addr == OFS_STAT) begin
                if (reg_wdata[STAT_DONE]) done_q <= 1'b0;
                if (reg_wdata[STAT_DERR]) err_q  <= 1'b0;
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFS_STAT:  reg_rdata = {5'd0, err_q, done_q, busy};
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_TADDR: reg_rdata = taddr_q;
            OFS_CMD:   reg_rdata = cmd_q;
            OFS_DATA:  reg_rdata = data_q;
            OFS_DIV:   reg_rdata = 8'(div_q);
            default:   reg_rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/smb_host_chk.sv
module smb_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [7:0] cmd_q
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R13

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R6

    AST_FLAGS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (!done && !err)); // R6

    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(busy)); // R6

    AST_ERR_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy)); // R7

    AST_START_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!done && !err)); // R9

    AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cmd_q)); // R10
endmodule

bind smb_host smb_host_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done_q), .err(err_q),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .cmd_q(cmd_q)
);

// File: tb/tb_smb_host.sv
`timescale 1ns/1ps
module tb_smb_host;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe, sda_oe, scl_w, sda_w;
    logic       s_sda_low = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign scl_w = !scl_oe;
    assign sda_w = !(sda_oe || s_sda_low);

    smb_host dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .scl_in(scl_w), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural target ----------------
    int         ph = 0, cnt = 0, n_start = 0, n_stop = 0, cyc = 0;
    bit         first = 0, is_rd = 0, s_nack_data = 0;
    logic [7:0] rx = 0, tx = 8'h00;
    logic [6:0] s_addr = 7'h50;
    logic       m_ack = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
    logic [7:0] log_q[$];
    int         rises[$];

    always @(negedge clk) begin
        cyc++;
        if (scl_w && p_scl && p_sda && !sda_w) begin
            ph = 1; cnt = 0; first = 1; s_sda_low = 0; n_start++;
        end else if (scl_w && p_scl && !p_sda && sda_w) begin
            ph = 0; s_sda_low = 0; n_stop++;
        end else if (scl_w && !p_scl) begin
            rises.push_back(cyc);
            if (ph == 1) begin rx = {rx[6:0], sda_w}; cnt++; end
            else if (ph == 3) cnt++;
            else if (ph == 4) begin m_ack = sda_w; ph = 5; end
        end else if (!scl_w && p_scl) begin
            if (ph == 1 && cnt == 8) begin
                log_q.push_back(rx);
                if (first) is_rd = rx[0];
                if (first ? (rx[7:1] == s_addr) : !s_nack_data) begin
                    s_sda_low = 1; ph = 2;
                end else ph = 0;
            end else if (ph == 2) begin
                s_sda_low = 0; cnt = 0;
                if (first && is_rd) begin ph = 3; s_sda_low = !tx[7]; end
                else ph = 1;
                first = 0;
            end else if (ph == 3) begin
                if (cnt < 8) s_sda_low = !tx[7 - cnt];
                else begin s_sda_low = 0; ph = 4; end
            end else if (ph == 5) ph = 0;
        end
        p_scl = scl_w;
        p_sda = sda_w;
    end

    // ---------------- reference model of bus ownership ----------------
    bit       m_busy = 0;
    logic [1:0] m_flags = 2'b00;

    always @(negedge clk) begin
        if (rst_n && !m_busy) begin
            checks++;
            if (scl_oe || sda_oe) begin
                errors++;
                $display("FAIL R13 actual scl_oe=%0b sda_oe=%0b expected 0 0", scl_oe, sda_oe);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        if (a == 3'd1 && d[6] && !m_busy && m_flags == 2'b00 &&
            (d[4:2] == 3'b001 || d[4:2] == 3'b010)) m_busy = 1;
        if (a == 3'd0 && !m_busy) m_flags = m_flags & ~d[2:1];
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_done(input string req, input logic [7:0] exp);
        logic [7:0] s;
        int n = 0;
        s = 8'h01;
        while (s[0] && n < 20000) begin rd(3'd0, s); n++; end
        m_busy = 0;
        m_flags = exp[2:1];
        check(req, s, exp);
    endtask

    task automatic check_log(input string req, input int n, input logic [31:0] e);
        check(req, log_q.size(), n);
        for (int i = 0; i < n && i < log_q.size(); i++)
            check(req, log_q[i], e[31 - 8*i -: 8]);
    endtask

    task automatic new_txn();
        log_q.delete();
        rises.delete();
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int st0, sp0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(3'd0, v); check("R1 status", v, 8'h00);
        rd(3'd5, v); check("R1 divider", v, 8'd9);
        check("R1 lines", {scl_oe, sda_oe}, 0);

        // R12 control readback, R9 invalid mode start ignored
        wr(3'd1, 8'hA3); rd(3'd1, v); check("R12 ctrl", v, 8'hA3);
        wr(3'd1, 8'hE3); rd(3'd1, v); check("R12 start bit reads 0", v, 8'hA3);
        repeat (20) @(negedge clk);
        rd(3'd0, v); check("R9 bad mode ignored", v, 8'h00);

        wr(3'd5, 8'd2);

        // R4 byte-data write, R6 busy then done, R11 timing
        new_txn(); sp0 = n_stop;
        wr(3'd2, 8'hA0); wr(3'd3, 8'h12); wr(3'd4, 8'hA5);
        wr(3'd1, 8'h48);
        rd(3'd0, v); check("R6 busy", v, 8'h01);
        wait_done("R6 done", 8'h02);
        check_log("R4 bytes", 3, {8'hA0, 8'h12, 8'hA5, 8'h00});
        check("R4 stop", n_stop - sp0, 1);
        check("R11 div2 spacing", rises[1] - rises[0], 12);

        // R8 clear
        wr(3'd0, 8'hFF); rd(3'd0, v); check("R8 clear done", v, 8'h00);

        // R5 byte-data read
        new_txn(); tx = 8'h3C; st0 = n_start;
        wr(3'd2, 8'hA1); wr(3'd3, 8'h34); wr(3'd1, 8'h48);
        wait_done("R5 status", 8'h02);
        check_log("R5 bytes", 3, {8'hA0, 8'h34, 8'hA1, 8'h00});
        rd(3'd4, v); check("R5 data", v, 8'h3C);
        check("R5 nack", m_ack, 1);
        check("R5 restart", n_start - st0, 2);
        wr(3'd0, 8'h02);

        // R2 send byte
        new_txn();
        wr(3'd2, 8'hA0); wr(3'd4, 8'h77); wr(3'd1, 8'h44);
        wait_done("R2 status", 8'h02);
        check_log("R2 bytes", 2, {8'hA0, 8'h77, 16'h0});
        wr(3'd0, 8'h02);

        // R3 receive byte
        new_txn(); tx = 8'h9E; m_ack = 0;
        wr(3'd2, 8'hA1); wr(3'd1, 8'h44);
        wait_done("R3 status", 8'h02);
        check_log("R3 bytes", 1, {8'hA1, 24'h0});
        rd(3'd4, v); check("R3 data", v, 8'h9E);
        check("R3 nack", m_ack, 1);
        wr(3'd0, 8'h02);

        // R7 address not acknowledged
        new_txn(); sp0 = n_stop;
        wr(3'd2, 8'hB1); wr(3'd1, 8'h48);
        wait_done("R7 addr nack status", 8'h04);
        check_log("R7 addr only", 1, {8'hB0, 24'h0});
        check("R7 stop", n_stop - sp0, 1);
        rd(3'd4, v); check("R7 data kept", v, 8'h9E);

        // R9 start while error pending
        new_txn();
        wr(3'd1, 8'h48);
        repeat (60) @(negedge clk);
        rd(3'd0, v); check("R9 pending ignored", v, 8'h04);
        check("R9 no bus bytes", log_q.size(), 0);

        // R8 busy bit not clearable, error cleared by one
        wr(3'd0, 8'h01); rd(3'd0, v); check("R8 bit0 write", v, 8'h04);
        wr(3'd0, 8'h04); rd(3'd0, v); check("R8 clear err", v, 8'h00);

        // R7 data byte not acknowledged
        new_txn(); s_nack_data = 1;
        wr(3'd2, 8'hA0); wr(3'd3, 8'h55); wr(3'd1, 8'h48);
        wait_done("R7 data nack status", 8'h04);
        check_log("R7 data nack bytes", 2, {8'hA0, 8'h55, 16'h0});
        s_nack_data = 0;
        wr(3'd0, 8'h04);

        // R10 writes during busy ignored, R9 restart while busy, R11 slower divider
        wr(3'd5, 8'd5);
        new_txn(); sp0 = n_stop;
        wr(3'd2, 8'hA0); wr(3'd3, 8'h21); wr(3'd4, 8'h66); wr(3'd1, 8'h48);
        wr(3'd3, 8'h99); wr(3'd4, 8'h99); wr(3'd2, 8'hC0); wr(3'd5, 8'd1);
        wr(3'd1, 8'h44);
        wait_done("R9 single txn status", 8'h02);
        check_log("R10 bytes", 3, {8'hA0, 8'h21, 8'h66, 8'h00});
        check("R9 one stop", n_stop - sp0, 1);
        rd(3'd3, v); check("R10 cmd", v, 8'h21);
        rd(3'd4, v); check("R10 data", v, 8'h66);
        rd(3'd2, v); check("R10 target", v, 8'hA0);
        rd(3'd5, v); check("R10 divider", v, 8'd5);
        rd(3'd1, v); check("R10 ctrl", v, 8'h08);
        check("R11 div5 spacing", rises[1] - rises[0], 24);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule